// File: doc/BRIEF.md
# Byte-wide host port bridge

This block connects an 8-bit parallel host bus to a processor core that works in 24-bit words. The host drives a chip select, a 3-bit byte address, separate active-low read and write strobes, and data on eight shared pins. The host sends a word toward the core by writing three byte registers. The write to the least significant byte hands the assembled word to a core-side holding register. Words from the core go the other way: the host reads them back through three byte registers. Two handshake flags pace both directions: "receive full" on the host read side and "transmit empty" on the host write side.

The host can also ask the core for an interrupt. It writes a command byte whose top bit is the request and whose low seven bits are the vector. While a request is pending, further command writes are dropped, so the core always sees a stable vector. A core-side configuration path decides whether the eight pins serve the host bus or act as general-purpose I/O with a per-pin direction. All host strobes cross into the core clock through two-flop synchronizers, and each host access takes effect when its strobe is released.

Top module: `hostport_bridge`

## Requirements
- R1: After reset, receive-full is 0, transmit-empty is 1, no interrupt request is pending, the port is in general-purpose mode with every pin an input (pad_oe = 0), and the core interface shows core_tx_ready = 1 and core_rx_valid = 0.
- R2: Writing configuration select 0 with bit 0 set puts the pins in host mode. A host read of address 0 then returns a status byte: bit 0 = receive full, bit 1 = transmit empty, bit 2 = interrupt request pending, all other bits 0. During any host read in host mode, pad_oe is all ones.
- R3: A core_tx_load while receive-full is clear captures core_tx_word and sets receive-full. The host then reads the word as bits 23:16 at address 5, bits 15:8 at address 6 and bits 7:0 at address 7. A load while receive-full is set is ignored. core_tx_ready equals the inverse of receive-full.
- R4: Completing a host read of address 7 clears receive-full. Reads of addresses 5 and 6 leave it set.
- R5: Host writes to addresses 5 and 6 stage the high and middle bytes. A write to address 7 while transmit-empty is set transfers {high, middle, written byte} to core_rx_word and clears transmit-empty. core_rx_valid is the inverse of transmit-empty.
- R6: A core_rx_take pulse sets transmit-empty again. A write to address 7 while transmit-empty is clear is ignored and leaves core_rx_word unchanged. Writes to addresses 5 and 6 are always staged.
- R7: A host write to address 1 while no request is pending loads the vector from bits 6:0 and the request bit from bit 7. irq_req and irq_vector show these values, and a host read of address 1 returns {request, vector}.
- R8: A host write to address 1 while a request is pending is ignored. irq_ack clears the pending request.
- R9: In general-purpose mode, pad_oe equals the direction byte (configuration select 1), pad_out equals the output byte (configuration select 2), and host strobes have no effect.
- R10: Pin inputs and host strobes pass through two clock stages. core_gpio_in follows pad_in two core clocks later. A host write takes effect only after its strobe is released, never while it is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| hcs_n | input | 1 | Host chip select, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| haddr | input | 3 | Host byte address |
| pad_in | input | 8 | Pin input values (host write data in host mode) |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Per-pin output enable |
| core_tx_word | input | 24 | Word from the core for the host to read |
| core_tx_load | input | 1 | Core loads core_tx_word |
| core_tx_ready | output | 1 | Host read registers are free |
| core_rx_word | output | 24 | Word written by the host |
| core_rx_valid | output | 1 | core_rx_word holds an untaken word |
| core_rx_take | input | 1 | Core has taken core_rx_word |
| irq_req | output | 1 | Host interrupt request pending |
| irq_vector | output | 7 | Requested interrupt vector |
| irq_ack | input | 1 | Core acknowledges the request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 mode, 1 direction, 2 output data |
| cfg_wdata | input | 8 | Configuration write data |
| core_gpio_in | output | 8 | Synchronized pin inputs |

## Verification
The hardest cases are the collisions between host and core traffic: a new word written to address 7 while the core still holds the previous one, a command write that arrives while a request is pending, and the moment in the middle of a held strobe before the event has crossed the synchronizer. The stimulus reaches these with directed sequences that withhold core_rx_take or irq_ack on purpose and that sample in the middle of a stretched strobe. Seeded random words then run through both directions and are compared with byte-split expectations computed in the bench.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd1;

  // Byte registers occupy the top of the address space, most significant first.
  function automatic logic [ADDR_W-1:0] byte_addr(input int unsigned nbytes,
                                                  input int unsigned idx_from_high);
    return ADDR_W'((1 << ADDR_W) - nbytes + idx_from_high);
  endfunction

  function automatic logic [7:0] status_byte(input logic full, input logic empty,
                                             input logic pend);
    return {5'b0, pend, empty, full};
  endfunction
endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[i] <= RST_VAL;
        else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hpb_host_events.sv
module hpb_host_events
  import hpb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hcs_n,
  input  logic              hrd_n,
  input  logic              hwr_n,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [BYTE_W-1:0] hdata,
  output logic              wr_evt,
  output logic              rd_evt,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [BYTE_W-1:0] evt_data
);
  logic [2:0] ctl_s;
  logic [ADDR_W+BYTE_W-1:0] bus_s;
  logic wr_act, rd_act, wr_q, rd_q;

  hpb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({hcs_n, hrd_n, hwr_n}), .q(ctl_s));

  hpb_sync #(.W(ADDR_W+BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({haddr, hdata}), .q(bus_s));

  assign wr_act = enable && !ctl_s[2] && !ctl_s[0];
  assign rd_act = enable && !ctl_s[2] && !ctl_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      evt_addr <= '0;
      evt_data <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act || rd_act) {evt_addr, evt_data} <= bus_s;
    end
  end

  // An access acts once, on the release of its strobe.
  assign wr_evt = enable && wr_q && !wr_act;
  assign rd_evt = enable && rd_q && !rd_act;

  a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
endmodule

// File: rtl/hpb_xfer.sv
module hpb_xfer
  import hpb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BYTES = 3,
  localparam int WORD_W = BYTE_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [BYTE_W-1:0] evt_data,
  input  logic [WORD_W-1:0] core_tx_word,
  input  logic              core_tx_load,
  input  logic              core_rx_take,
  output logic [WORD_W-1:0] rx_word,
  output logic              rxdf,
  output logic              txde,
  output logic [WORD_W-1:0] core_rx_word
);
  localparam logic [ADDR_W-1:0] LOW_A = byte_addr(BYTES, BYTES - 1);

  logic [WORD_W-1:0] staged;
  logic low_wr, low_rd, push, load_ok;

  for (genvar i = 0; i < BYTES - 1; i++) begin : g_stage
    localparam logic [ADDR_W-1:0] MY_A = byte_addr(BYTES, i);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           q <= '0;
      else if (wr_evt && evt_addr == MY_A)  q <= evt_data;
    assign staged[WORD_W-1-i*BYTE_W -: BYTE_W] = q;
  end
  assign staged[BYTE_W-1:0] = evt_data;

  assign low_wr  = wr_evt && (evt_addr == LOW_A);
  assign low_rd  = rd_evt && (evt_addr == LOW_A);
  assign push    = low_wr && txde;
  assign load_ok = core_tx_load && !rxdf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxdf    <= 1'b0;
      rx_word <= '0;
    end else if (load_ok) begin
      rxdf    <= 1'b1;
      rx_word <= core_tx_word;
    end else if (low_rd) begin
      rxdf    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txde         <= 1'b1;
      core_rx_word <= '0;
    end else if (push) begin
      txde         <= 1'b0;
      core_rx_word <= staged;
    end else if (core_rx_take) begin
      txde         <= 1'b1;
    end
  end

  a_r3_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    (core_tx_load && !rxdf) |=> (rxdf && rx_word == $past(core_tx_word)));
  a_r3_full_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rxdf && $past(rxdf)) |-> $stable(rx_word));
  a_r4_full_falls_on_low_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxdf) |-> $past(rd_evt && evt_addr == LOW_A));
  a_r5_push_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (low_wr && txde) |=> !txde);
  a_r6_empty_rises_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txde) |-> $past(core_rx_take));
  a_r6_word_held_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!txde && $past(!txde)) |-> $stable(core_rx_word));
endmodule

// File: rtl/hpb_cmd.sv
module hpb_cmd
  import hpb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int VEC_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [BYTE_W-1:0] evt_data,
  input  logic              irq_ack,
  output logic              pend,
  output logic [VEC_W-1:0]  vec
);
  logic cmd_wr;
  assign cmd_wr = wr_evt && (evt_addr == A_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      vec  <= '0;
    end else if (pend) begin
      if (irq_ack) pend <= 1'b0;
    end else if (cmd_wr) begin
      pend <= evt_data[BYTE_W-1];
      vec  <= evt_data[VEC_W-1:0];
    end
  end

  a_r8_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> $stable(vec));
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && irq_ack) |=> !pend);
endmodule

// File: rtl/hpb_pins.sv
module hpb_pins
  import hpb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BYTES = 3,
  parameter int VEC_W = 7,
  localparam int WORD_W = BYTE_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              hcs_n,
  input  logic              hrd_n,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              rxdf,
  input  logic              txde,
  input  logic              pend,
  input  logic [VEC_W-1:0]  vec,
  input  logic [WORD_W-1:0] rx_word,
  output logic              host_en,
  output logic [BYTE_W-1:0] pad_out,
  output logic [BYTE_W-1:0] pad_oe
);
  logic [BYTE_W-1:0] dir_q, gout_q, rd_byte;
  logic host_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_en <= 1'b0;
      dir_q   <= '0;
      gout_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    host_en <= cfg_wdata[0];
        2'd1:    dir_q   <= cfg_wdata;
        2'd2:    gout_q  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_byte = '0;
    if (haddr == A_STATUS) rd_byte = BYTE_W'(status_byte(rxdf, txde, pend));
    if (haddr == A_CMD) begin
      rd_byte = BYTE_W'(vec);
      rd_byte[BYTE_W-1] = pend;
    end
    for (int i = 0; i < BYTES; i++)
      if (haddr == byte_addr(BYTES, i))
        rd_byte = rx_word[WORD_W-1-i*BYTE_W -: BYTE_W];
  end

  assign host_rd = !hcs_n && !hrd_n;
  assign pad_out = host_en ? rd_byte : gout_q;
  assign pad_oe  = host_en ? {BYTE_W{host_rd}} : dir_q;

  a_r9_gpio_drive_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_en && $past(!host_en) && !$past(cfg_we)) |-> ($stable(pad_oe) && $stable(pad_out)));
endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
  import hpb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BYTES = 3,
  parameter int VEC_W = 7,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = BYTE_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hcs_n,
  input  logic              hrd_n,
  input  logic              hwr_n,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [BYTE_W-1:0] pad_in,
  output logic [BYTE_W-1:0] pad_out,
  output logic [BYTE_W-1:0] pad_oe,
  input  logic [WORD_W-1:0] core_tx_word,
  input  logic              core_tx_load,
  output logic              core_tx_ready,
  output logic [WORD_W-1:0] core_rx_word,
  output logic              core_rx_valid,
  input  logic              core_rx_take,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] core_gpio_in
);
  logic host_en, wr_evt, rd_evt, rxdf, txde;
  logic [ADDR_W-1:0] evt_addr;
  logic [BYTE_W-1:0] evt_data;
  logic [WORD_W-1:0] rx_word;

  hpb_host_events #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk(clk), .rst_n(rst_n), .enable(host_en),
    .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n), .haddr(haddr), .hdata(pad_in),
    .wr_evt(wr_evt), .rd_evt(rd_evt), .evt_addr(evt_addr), .evt_data(evt_data));

  hpb_xfer #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_xfer (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .evt_addr(evt_addr), .evt_data(evt_data),
    .core_tx_word(core_tx_word), .core_tx_load(core_tx_load), .core_rx_take(core_rx_take),
    .rx_word(rx_word), .rxdf(rxdf), .txde(txde), .core_rx_word(core_rx_word));

  hpb_cmd #(.BYTE_W(BYTE_W), .VEC_W(VEC_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .evt_addr(evt_addr),
    .evt_data(evt_data), .irq_ack(irq_ack), .pend(irq_req), .vec(irq_vector));

  hpb_pins #(.BYTE_W(BYTE_W), .BYTES(BYTES), .VEC_W(VEC_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hcs_n(hcs_n), .hrd_n(hrd_n), .haddr(haddr),
    .rxdf(rxdf), .txde(txde), .pend(irq_req), .vec(irq_vector), .rx_word(rx_word),
    .host_en(host_en), .pad_out(pad_out), .pad_oe(pad_oe));

  hpb_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_gpio_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(core_gpio_in));

  assign core_tx_ready = !rxdf;
  assign core_rx_valid = !txde;

  a_r9_no_host_effect_in_gpio: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_en && !irq_ack && !core_rx_take) |=> ($stable(irq_req) && $stable(core_rx_valid)));
endmodule

// File: tb/hostport_bridge_bench.sv
module hostport_bridge_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hcs_n = 1'b1, hrd_n = 1'b1, hwr_n = 1'b1;
  logic [2:0] haddr = '0;
  logic [7:0] pad_in = '0, pad_out, pad_oe;
  logic [23:0] core_tx_word = '0, core_rx_word;
  logic core_tx_load = 1'b0, core_tx_ready, core_rx_valid, core_rx_take = 1'b0;
  logic irq_req, irq_ack = 1'b0;
  logic [6:0] irq_vector;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0, core_gpio_in;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  hostport_bridge u_hostport_bridge (.*);

  function automatic logic [7:0] exp_status(logic full, logic empty, logic pend);
    return {5'b0, pend, empty, full};
  endfunction
  function automatic logic [7:0] byte_of(logic [23:0] w, int idx_from_high);
    return w[23 - 8*idx_from_high -: 8];
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic cfg(logic [1:0] s, logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic host_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk); haddr = a; pad_in = d; hcs_n = 1'b0; hwr_n = 1'b0;
    repeat (4) @(negedge clk);
    hwr_n = 1'b1; hcs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask
  task automatic host_read(logic [2:0] a, output logic [7:0] d, output logic [7:0] oe);
    @(negedge clk); haddr = a; hcs_n = 1'b0; hrd_n = 1'b0;
    repeat (2) @(negedge clk);
    d = pad_out; oe = pad_oe;
    repeat (2) @(negedge clk);
    hrd_n = 1'b1; hcs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask
  task automatic core_load(logic [23:0] w);
    @(negedge clk); core_tx_word = w; core_tx_load = 1'b1;
    @(negedge clk); core_tx_load = 1'b0;
    @(negedge clk);
  endtask
  task automatic pulse_take();
    @(negedge clk); core_rx_take = 1'b1;
    @(negedge clk); core_rx_take = 1'b0;
    @(negedge clk);
  endtask
  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, oe;
    logic [23:0] w;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 irq_req", irq_req, 1'b0);
    check("R1 core_rx_valid", core_rx_valid, 1'b0);
    check("R1 core_tx_ready", core_tx_ready, 1'b1);

    // R9 general-purpose mode
    cfg(2'd1, 8'hF0);
    cfg(2'd2, 8'hA5);
    check("R9 pad_oe", pad_oe, 8'hF0);
    check("R9 pad_out", pad_out, 8'hA5);
    // R10 two-stage input path
    pad_in = 8'h3C;
    @(negedge clk);
    check("R10 gpio one stage", core_gpio_in, 8'h00);
    @(negedge clk);
    check("R10 gpio two stages", core_gpio_in, 8'h3C);
    host_write(3'd1, 8'h85);
    check("R9 strobe ignored irq", irq_req, 1'b0);
    host_write(3'd5, 8'h11); host_write(3'd6, 8'h22); host_write(3'd7, 8'h33);
    check("R9 strobe ignored rx", core_rx_valid, 1'b0);
    host_read(3'd0, d, oe);
    check("R9 oe during read", oe, 8'hF0);

    // R2 host mode
    cfg(2'd0, 8'h01);
    host_read(3'd0, d, oe);
    check("R2 status", d, exp_status(1'b0, 1'b1, 1'b0));
    check("R2 oe", oe, 8'hFF);

    // R3 / R4 core-to-host path
    core_load(24'h123456);
    check("R3 ready low", core_tx_ready, 1'b0);
    core_load(24'hFFFFFF);
    host_read(3'd0, d, oe);
    check("R3 status full", d, exp_status(1'b1, 1'b1, 1'b0));
    host_read(3'd5, d, oe); check("R3 high byte", d, 8'h12);
    host_read(3'd6, d, oe); check("R3 mid byte", d, 8'h34);
    host_read(3'd0, d, oe);
    check("R4 still full", d, exp_status(1'b1, 1'b1, 1'b0));
    host_read(3'd7, d, oe); check("R3 low byte, load while full ignored", d, 8'h56);
    check("R4 ready after low read", core_tx_ready, 1'b1);

    // R5 / R10 host-to-core path
    host_write(3'd5, 8'hAB);
    host_write(3'd6, 8'hCD);
    @(negedge clk); haddr = 3'd7; pad_in = 8'hEF; hcs_n = 1'b0; hwr_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 no effect while strobe held", core_rx_valid, 1'b0);
    hwr_n = 1'b1; hcs_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 valid", core_rx_valid, 1'b1);
    check("R5 word", core_rx_word, 24'hABCDEF);
    host_read(3'd0, d, oe);
    check("R5 status", d, exp_status(1'b0, 1'b0, 1'b0));

    // R6 overwrite refused, take, staged bytes kept
    host_write(3'd5, 8'h11); host_write(3'd6, 8'h22); host_write(3'd7, 8'h33);
    check("R6 word kept", core_rx_word, 24'hABCDEF);
    pulse_take();
    check("R6 valid cleared", core_rx_valid, 1'b0);
    host_write(3'd7, 8'h44);
    check("R6 staged bytes kept", core_rx_word, 24'h112244);
    pulse_take();

    // R7 / R8 command path
    host_write(3'd1, 8'h85);
    check("R7 irq_req", irq_req, 1'b1);
    check("R7 vector", irq_vector, 7'h05);
    host_read(3'd1, d, oe); check("R7 readback", d, 8'h85);
    host_read(3'd0, d, oe); check("R7 status", d, exp_status(1'b0, 1'b1, 1'b1));
    host_write(3'd1, 8'h9F);
    check("R8 vector held", irq_vector, 7'h05);
    pulse_ack();
    check("R8 ack clears", irq_req, 1'b0);
    host_write(3'd1, 8'h1F);
    check("R7 vector no request", irq_vector, 7'h1F);
    check("R7 no request", irq_req, 1'b0);
    host_write(3'd1, 8'hBF);
    check("R7 vector second", irq_vector, 7'h3F);
    pulse_ack();

    // random words, both directions (R3 R4 R5 R6)
    for (int it = 0; it < 16; it++) begin
      w = 24'($urandom);
      core_load(w);
      for (int b = 0; b < 3; b++) begin
        host_read(3'(5 + b), d, oe);
        check("R3 random byte", d, byte_of(w, b));
      end
      check("R4 random ready", core_tx_ready, 1'b1);
      w = 24'($urandom);
      for (int b = 0; b < 3; b++) host_write(3'(5 + b), byte_of(w, b));
      check("R5 random word", core_rx_word, w);
      pulse_take();
      check("R6 random empty", core_rx_valid, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule